// File: doc/BRIEF.md
# Dual-Input Up/Down Binary Counter

This block is a synchronous binary counter with two count inputs instead of a clock and a direction pin. A rising edge on the up input adds one. A rising edge on the down input subtracts one. The input that is not being pulsed is held high. Both count inputs come from outside the system clock domain. Each one passes through a synchronizer and an edge detector before it can step the count. All state bits then change together on a single system clock edge, so the output never shows a partial value.

Beside the count inputs there are three controls:
- a synchronous clear, active high;
- a parallel load, active low, with a data word;
- two active-low status outputs, one flagging the top of the up range and one the bottom of the down range, so that a following stage can chain off them.

The count wraps at its natural modulus.

Top module: `updn_counter`

## Requirements
- R1: While the system reset is asserted, and after it is released with both count inputs high, the count reads 0, and carryN and borrowN both read 1.
- R2: Each rising edge on upCntIn adds 1 to the count, exactly once per edge, however long the input then stays high.
- R3: Each rising edge on dnCntIn subtracts 1 from the count, exactly once per edge.
- R4: Counting wraps modulo 2^WIDTH: one up step from all ones gives 0, and one down step from 0 gives all ones.
- R5: If both count inputs rise in the same synchronized cycle, the count keeps its value.
- R6: clrIn high forces the count to 0 on the next clock edge. It overrides a load and any count edge that arrives while it is high.
- R7: loadN low copies dataIn into the count on the next clock edge. Count edges that arrive while loadN is low are ignored.
- R8: carryN reads 0 exactly while the count is all ones and the synchronized upCntIn is low. Otherwise it reads 1.
- R9: borrowN reads 0 exactly while the count is 0 and the synchronized dnCntIn is low. Otherwise it reads 1.
- R10: A falling edge on either count input leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| upCntIn | input | 1 | Up count input; its rising edge increments |
| dnCntIn | input | 1 | Down count input; its rising edge decrements |
| clrIn | input | 1 | Synchronous clear, active high |
| loadN | input | 1 | Parallel load enable, active low |
| dataIn | input | WIDTH | Value copied into the count on a load |
| countOut | output | WIDTH | Current count |
| carryN | output | 1 | Low while at all ones with the up input low |
| borrowN | output | 1 | Low while at zero with the down input low |

## Verification
The bench builds the counter with its default parameters: WIDTH of 4 and two synchronizer stages. With these values every count code and both wrap points are reached after a handful of loads and pulses. The latency from a count-input edge to a count change, two synchronizer flops plus the count register, stays short enough to check each scenario within a few cycles. The status outputs are checked at both ends of the range and one code away from each end.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;

  // Strobes handed from the control unit to the datapath each cycle.
  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
    logic dec;
  } ctrlStrobes_t;

  localparam int NUM_CNT_INPUTS = 2;
  localparam int UP_IDX = 0;
  localparam int DN_IDX = 1;

endpackage

// File: rtl/updn_sync_edge.sv
module updn_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic rise
);

  // pipe[STAGES-1] is the synchronized level; pipe[STAGES] is its
  // previous value, used for edge detection. Reset to ones so that an
  // idle-high input gives no false edge when reset is released.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];

  // One edge yields exactly one rise strobe (R2, R3)
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);

endmodule

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_counter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         upCntIn,
  input  logic         dnCntIn,
  input  logic         clrIn,
  input  logic         loadN,
  output ctrlStrobes_t strobes,
  output logic         upLevel,
  output logic         dnLevel
);

  logic [NUM_CNT_INPUTS-1:0] rawIn;
  logic [NUM_CNT_INPUTS-1:0] syncLevel;
  logic [NUM_CNT_INPUTS-1:0] syncRise;

  assign rawIn[UP_IDX] = upCntIn;
  assign rawIn[DN_IDX] = dnCntIn;

  for (genvar ch = 0; ch < NUM_CNT_INPUTS; ch++) begin : g_chan
    updn_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rstN  (rstN),
      .din   (rawIn[ch]),
      .level (syncLevel[ch]),
      .rise  (syncRise[ch])
    );
  end

  logic countAllowed;
  assign countAllowed = !clrIn && loadN;

  always_comb begin
    strobes      = '0;
    strobes.clr  = clrIn;
    strobes.load = !clrIn && !loadN;
    strobes.inc  = countAllowed && syncRise[UP_IDX] && !syncRise[DN_IDX];
    strobes.dec  = countAllowed && syncRise[DN_IDX] && !syncRise[UP_IDX];
  end

  assign upLevel = syncLevel[UP_IDX];
  assign dnLevel = syncLevel[DN_IDX];

  // At most one action per cycle (R5, R6, R7)
  assert_one_action_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clr, strobes.load, strobes.inc, strobes.dec}));

  // No count step while clear or load is active (R7)
  assert_load_blocks_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN || clrIn) |-> !(strobes.inc || strobes.dec));

endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             upLevel,
  input  logic             dnLevel,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);

  localparam logic [WIDTH-1:0] MAX_VAL = '1;
  localparam logic [WIDTH-1:0] ONE_VAL = WIDTH'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strobes.clr)  count <= '0;
    else if (strobes.load) count <= dataIn;
    else if (strobes.inc)  count <= count + ONE_VAL;
    else if (strobes.dec)  count <= count - ONE_VAL;
  end

  logic atMax;
  logic atMin;
  assign atMax   = (count == MAX_VAL);
  assign atMin   = (count == '0);
  assign carryN  = !(atMax && !upLevel);
  assign borrowN = !(atMin && !dnLevel);

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> (count == '0));

  assert_load_copies_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (count == $past(dataIn)));

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.inc |=> (count == $past(count) + ONE_VAL));

  assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dec |=> (count == $past(count) - ONE_VAL));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.clr || strobes.load || strobes.inc || strobes.dec) |=> $stable(count));

endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upCntIn,
  input  logic             dnCntIn,
  input  logic             clrIn,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] countOut,
  output logic             carryN,
  output logic             borrowN
);

  ctrlStrobes_t strobes;
  logic         upLevel;
  logic         dnLevel;

  updn_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .upCntIn (upCntIn),
    .dnCntIn (dnCntIn),
    .clrIn   (clrIn),
    .loadN   (loadN),
    .strobes (strobes),
    .upLevel (upLevel),
    .dnLevel (dnLevel)
  );

  updn_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .upLevel (upLevel),
    .dnLevel (dnLevel),
    .dataIn  (dataIn),
    .count   (countOut),
    .carryN  (carryN),
    .borrowN (borrowN)
  );

  // Status outputs stay high whenever the count is strictly inside the range (R8, R9)
  assert_flags_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (countOut != '0 && countOut != '1) |-> (carryN && borrowN));

endmodule

// File: tb/test_updn_counter.sv
module test_updn_counter;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             upCntIn = 1'b1;
  logic             dnCntIn = 1'b1;
  logic             clrIn = 1'b0;
  logic             loadN = 1'b1;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] countOut;
  logic             carryN;
  logic             borrowN;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_counter #(.WIDTH(WIDTH), .SYNC_STAGES(2)) i_updn_counter (
    .clk      (clk),
    .rstN     (rstN),
    .upCntIn  (upCntIn),
    .dnCntIn  (dnCntIn),
    .clrIn    (clrIn),
    .loadN    (loadN),
    .dataIn   (dataIn),
    .countOut (countOut),
    .carryN   (carryN),
    .borrowN  (borrowN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit doUp, input bit doDn);
    @(negedge clk);
    if (doUp) upCntIn = 1'b0;
    if (doDn) dnCntIn = 1'b0;
    waitCycles(4);
    upCntIn = 1'b1;
    dnCntIn = 1'b1;
    waitCycles(5);
  endtask

  task automatic loadValue(input logic [WIDTH-1:0] v);
    @(negedge clk);
    loadN  = 1'b0;
    dataIn = v;
    @(negedge clk);
    loadN  = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 count", countOut, 0);
    check("R1 carryN", carryN, 1);
    check("R1 borrowN", borrowN, 1);
    @(negedge clk);
    rstN = 1'b1;
    waitCycles(5);
    check("R1 count after release", countOut, 0);
  endtask

  task automatic testUp();
    for (int i = 1; i <= 3; i++) begin
      pulse(1'b1, 1'b0);
      check("R2 up step", countOut, i);
    end
    waitCycles(8);
    check("R2 held high no repeat", countOut, 3);
  endtask

  task automatic testFalling();
    @(negedge clk);
    upCntIn = 1'b0;
    dnCntIn = 1'b0;
    waitCycles(6);
    check("R10 falling edges", countOut, 3);
    upCntIn = 1'b1;
    waitCycles(5);
    check("R2 rise after fall", countOut, 4);
    dnCntIn = 1'b1;
    waitCycles(5);
    check("R3 rise after fall", countOut, 3);
  endtask

  task automatic testDown();
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    check("R3 down steps", countOut, 1);
  endtask

  task automatic testLoad();
    loadValue(4'hA);
    check("R7 load value", countOut, 10);
    @(negedge clk);
    loadN  = 1'b0;
    dataIn = 4'h6;
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    check("R7 edges ignored in load", countOut, 6);
    loadN = 1'b1;
    waitCycles(3);
    check("R7 after load release", countOut, 6);
  endtask

  task automatic testWrap();
    loadValue(4'hF);
    pulse(1'b1, 1'b0);
    check("R4 up wrap", countOut, 0);
    pulse(1'b0, 1'b1);
    check("R4 down wrap", countOut, 15);
  endtask

  task automatic testCarry();
    loadValue(4'hE);
    @(negedge clk);
    upCntIn = 1'b0;
    waitCycles(4);
    check("R8 carry high below max", carryN, 1);
    upCntIn = 1'b1;
    waitCycles(5);
    check("R2 reached max", countOut, 15);
    check("R8 carry high with up high", carryN, 1);
    upCntIn = 1'b0;
    waitCycles(4);
    check("R8 carry low at max", carryN, 0);
    check("R9 borrow high at max", borrowN, 1);
    upCntIn = 1'b1;
    waitCycles(5);
    check("R4 wrap from carry", countOut, 0);
    check("R8 carry released", carryN, 1);
  endtask

  task automatic testBorrow();
    loadValue(4'h1);
    @(negedge clk);
    dnCntIn = 1'b0;
    waitCycles(4);
    check("R9 borrow high above min", borrowN, 1);
    dnCntIn = 1'b1;
    waitCycles(5);
    check("R3 reached zero", countOut, 0);
    check("R9 borrow high with down high", borrowN, 1);
    dnCntIn = 1'b0;
    waitCycles(4);
    check("R9 borrow low at zero", borrowN, 0);
    check("R8 carry high at zero", carryN, 1);
    dnCntIn = 1'b1;
    waitCycles(5);
    check("R4 wrap from borrow", countOut, 15);
    check("R9 borrow released", borrowN, 1);
  endtask

  task automatic testBoth();
    loadValue(4'h5);
    pulse(1'b1, 1'b1);
    check("R5 simultaneous rise", countOut, 5);
  endtask

  task automatic testClear();
    loadValue(4'h7);
    @(negedge clk);
    clrIn  = 1'b1;
    loadN  = 1'b0;
    dataIn = 4'h9;
    waitCycles(2);
    check("R6 clear over load", countOut, 0);
    pulse(1'b1, 1'b0);
    check("R6 clear over count", countOut, 0);
    clrIn = 1'b0;
    loadN = 1'b1;
    waitCycles(3);
    check("R6 after clear release", countOut, 0);
  endtask

  initial begin
    waitCycles(3);
    testReset();
    testUp();
    testFalling();
    testDown();
    testLoad();
    testWrap();
    testCarry();
    testBorrow();
    testBoth();
    testClear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule